// File: doc/BRIEF.md
# Motor-Control Timing and Strobe Generator

This block derives every periodic timing reference of a motor-control datapath from one system clock (20 MHz nominal). A clock counter defines the PWM/field-oriented-control cycle, whose length is a programmable number of clocks (default 917, about 21.8 kHz). A second counter groups a programmable whole number of PWM cycles (default 6) into one resolver excitation period. The position/speed loop tick (about 3.6 kHz at the defaults) is issued once per resolver period.

Inside these cycles the block issues single-clock strobes. The current-ADC acquisition strobe opens each PWM cycle. The strobe that starts the Clarke/Park transforms and the PI calculation follows after a programmable delay. A strobe marks the start of each excitation period. Up to 16 resolver sample strobes per excitation period are placed at programmable, non-uniform clock offsets from the start of the period. Each sample strobe carries the index of its table entry, so a correlation engine downstream can weight the sample.

All configuration comes in on plain input ports and must be held stable while the block is enabled. Dropping the synchronous enable clears every counter. Raising it again starts all cycles phase-aligned from clock zero.

Top module: `mc_timing_gen`

## Requirements
- R1: While reset is active or `en_i` was low at the last clock edge, every strobe output and `res_samp_idx_o` are 0. The first rising clock edge that samples `en_i` high is clock 0 of a new PWM and resolver period, so `adc_strobe_o` is high in the cycle that follows that edge.
- R2: With P = `pwm_period_i` (P >= 2), `adc_strobe_o` is a one-clock pulse for PWM count 0, which recurs every P enabled clocks.
- R3: `foc_start_o` pulses for PWM count D = `foc_delay_i` in every PWM cycle, D clocks after the ADC strobe. If D >= P it never pulses.
- R4: With N = `res_ratio_i` (N >= 1), `res_exc_o` pulses once every N*P enabled clocks. It always coincides with an ADC strobe, namely that of the first PWM cycle of the resolver period.
- R5: `pos_tick_o` pulses in the final clock (count N*P-1) of every resolver period, exactly one clock before the next `res_exc_o`.
- R6: Entry j of the offset table occupies bits [j*24 +: 24] of `samp_ofs_i`, in clocks from the start of the resolver period. Entries must be strictly increasing. When the resolver count equals entry j, `res_samp_o` pulses and `res_samp_idx_o` equals j. Otherwise the index output is 0.
- R7: A table entry of N*P or more produces no sample strobe, and sampling restarts at entry 0 in the next resolver period.
- R8: Lowering `en_i` for any number of clocks in the middle of a period, then raising it, restarts every cycle from count 0 with no strobe carried over from the interrupted period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Synchronous run enable; low clears all counters |
| pwm_period_i | input | 16 | PWM cycle length in clocks (P) |
| foc_delay_i | input | 16 | Clocks from ADC strobe to transform/PI start (D) |
| res_ratio_i | input | 8 | PWM cycles per resolver period (N) |
| samp_ofs_i | input | 384 | 16 resolver sample offsets, 24 bits each |
| adc_strobe_o | output | 1 | Current-ADC acquisition strobe, PWM cycle start |
| foc_start_o | output | 1 | Transform and PI calculation start strobe |
| res_exc_o | output | 1 | Resolver excitation period start strobe |
| res_samp_o | output | 1 | Resolver sample strobe |
| res_samp_idx_o | output | 4 | Table index of the current sample strobe |
| pos_tick_o | output | 1 | Position/speed loop tick |

## Verification
Every strobe is registered. It appears in the cycle that follows the rising edge at which the internal counters held its position, so the strobe for enabled count k is visible after the (k+1)-th enabled edge. The bench counts enabled edges itself and captures the configuration at each edge. At the falling edge that follows, it compares all six outputs against the strobes that the requirements predict for count k. This places the ADC strobe one cycle after enable, the transform strobe D cycles later, and the position tick one cycle before the excitation strobe. Drops of the enable, delays beyond the period and table entries beyond the resolver period each get their own phase.

// File: rtl/mc_timing_pkg.sv
package mc_timing_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned RATIO_W  = 8;
  localparam int unsigned NUM_SAMP = 16;

  typedef struct packed {
    logic adc;
    logic foc;
    logic exc;
    logic samp;
    logic pos;
  } strobe_t;
endpackage

// File: rtl/mc_pwm_timer.sv
module mc_pwm_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RATIO_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               cyc_last_o,
  output logic               res_last_o
);
  logic [RATIO_W-1:0] idx_q;

  assign cyc_last_o = (cnt_o == period_i - CNT_W'(1));
  assign res_last_o = cyc_last_o && (idx_q == ratio_i - RATIO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      idx_q <= '0;
    end else if (!en_i) begin
      cnt_o <= '0;
      idx_q <= '0;
    end else if (cyc_last_o) begin
      cnt_o <= '0;
      idx_q <= res_last_o ? '0 : idx_q + RATIO_W'(1);
    end else begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/mc_res_sampler.sv
module mc_res_sampler #(
  parameter int unsigned RW       = 24,
  parameter int unsigned NUM_SAMP = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_SAMP),
  localparam int unsigned PTR_W   = $clog2(NUM_SAMP + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   wrap_i,
  input  logic [NUM_SAMP*RW-1:0] ofs_i,
  output logic [RW-1:0]          rcnt_o,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       hit_idx_o
);
  logic [RW-1:0]    ofs [NUM_SAMP];
  logic [PTR_W-1:0] ptr_q;
  logic             live;

  for (genvar g = 0; g < NUM_SAMP; g++) begin : g_unpack
    assign ofs[g] = ofs_i[g*RW +: RW];
  end

  assign live      = (ptr_q < PTR_W'(NUM_SAMP));
  assign hit_idx_o = ptr_q[IDX_W-1:0];
  assign hit_o     = live && (rcnt_o == ofs[hit_idx_o]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_o <= '0;
      ptr_q  <= '0;
    end else if (!en_i || wrap_i) begin
      rcnt_o <= '0;
      ptr_q  <= '0;
    end else begin
      rcnt_o <= rcnt_o + RW'(1);
      if (hit_o) ptr_q <= ptr_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/mc_timing_gen.sv
module mc_timing_gen
  import mc_timing_pkg::*;
#(
  parameter int unsigned P_CNT_W    = CNT_W,
  parameter int unsigned P_RATIO_W  = RATIO_W,
  parameter int unsigned P_NUM_SAMP = NUM_SAMP,
  localparam int unsigned RW        = P_CNT_W + P_RATIO_W,
  localparam int unsigned IDX_W     = $clog2(P_NUM_SAMP)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [P_CNT_W-1:0]       pwm_period_i,
  input  logic [P_CNT_W-1:0]       foc_delay_i,
  input  logic [P_RATIO_W-1:0]     res_ratio_i,
  input  logic [P_NUM_SAMP*RW-1:0] samp_ofs_i,
  output logic                     adc_strobe_o,
  output logic                     foc_start_o,
  output logic                     res_exc_o,
  output logic                     res_samp_o,
  output logic [IDX_W-1:0]         res_samp_idx_o,
  output logic                     pos_tick_o
);
  logic [P_CNT_W-1:0] pwm_cnt;
  logic               cyc_last, res_last;
  logic [RW-1:0]      rcnt;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  strobe_t            stb_d, stb_q;
  logic [IDX_W-1:0]   idx_q;

  mc_pwm_timer #(.CNT_W(P_CNT_W), .RATIO_W(P_RATIO_W)) u_pwm (
    .clk_i, .rst_ni, .en_i,
    .period_i  (pwm_period_i),
    .ratio_i   (res_ratio_i),
    .cnt_o     (pwm_cnt),
    .cyc_last_o(cyc_last),
    .res_last_o(res_last)
  );

  mc_res_sampler #(.RW(RW), .NUM_SAMP(P_NUM_SAMP)) u_samp (
    .clk_i, .rst_ni, .en_i,
    .wrap_i   (res_last),
    .ofs_i    (samp_ofs_i),
    .rcnt_o   (rcnt),
    .hit_o    (hit),
    .hit_idx_o(hit_idx)
  );

  always_comb begin
    stb_d.adc  = (pwm_cnt == '0);
    stb_d.foc  = (pwm_cnt == foc_delay_i);
    stb_d.exc  = (rcnt == '0);
    stb_d.samp = hit;
    stb_d.pos  = res_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= '0;
      idx_q <= '0;
    end else if (!en_i) begin
      stb_q <= '0;
      idx_q <= '0;
    end else begin
      stb_q <= stb_d;
      idx_q <= hit ? hit_idx : '0;
    end
  end

  assign adc_strobe_o   = stb_q.adc;
  assign foc_start_o    = stb_q.foc;
  assign res_exc_o      = stb_q.exc;
  assign res_samp_o     = stb_q.samp;
  assign res_samp_idx_o = idx_q;
  assign pos_tick_o     = stb_q.pos;

  logic unused_cyc;
  assign unused_cyc = cyc_last;
endmodule

// File: rtl/mc_timing_chk.sv
module mc_timing_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             adc_strobe_o,
  input logic             foc_start_o,
  input logic             res_exc_o,
  input logic             res_samp_o,
  input logic [IDX_W-1:0] res_samp_idx_o,
  input logic             pos_tick_o
);
  logic en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !(adc_strobe_o || foc_start_o || res_exc_o || res_samp_o || pos_tick_o));

  a_r2_adc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_strobe_o |=> !adc_strobe_o);

  a_r3_foc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    foc_start_o |=> !foc_start_o);

  a_r4_exc_on_adc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_exc_o |-> adc_strobe_o);

  a_r5_pos_then_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_tick_o && en_i) |=> res_exc_o);

  a_r6_idx_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_samp_o |-> (res_samp_idx_o == '0));
endmodule

bind mc_timing_gen mc_timing_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .adc_strobe_o  (adc_strobe_o),
  .foc_start_o   (foc_start_o),
  .res_exc_o     (res_exc_o),
  .res_samp_o    (res_samp_o),
  .res_samp_idx_o(res_samp_idx_o),
  .pos_tick_o    (pos_tick_o)
);

// File: tb/mc_timing_gen_bench.sv
`timescale 1ns/1ps
module mc_timing_gen_bench;
  localparam int CLK_PERIOD = 50;
  localparam int NS = 16;
  localparam int RW = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [15:0]    period = 16'd20;
  logic [15:0]    delay = 16'd7;
  logic [7:0]     ratio = 8'd3;
  logic [NS*RW-1:0] ofs_flat = '0;
  logic           adc, foc, exc, samp, pos;
  logic [3:0]     sidx;

  int ofs_tab [NS];
  int nchk = 0, nfail = 0;
  string ph = "R1 reset";

  int  kcnt = 0, kcur = 0;
  bit  en_seen = 0;
  int  mP = 2, mD = 0, mN = 1;
  int  mofs [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_timing_gen u_mc_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .pwm_period_i(period), .foc_delay_i(delay), .res_ratio_i(ratio),
    .samp_ofs_i(ofs_flat),
    .adc_strobe_o(adc), .foc_start_o(foc), .res_exc_o(exc),
    .res_samp_o(samp), .res_samp_idx_o(sidx), .pos_tick_o(pos)
  );

  // reference: count enabled edges, capture configuration
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_seen = 0;
      kcnt = 0;
    end else begin
      en_seen = en;
      if (en) begin
        kcur = kcnt;
        kcnt++;
        mP = period; mD = delay; mN = ratio;
        for (int j = 0; j < NS; j++) mofs[j] = ofs_tab[j];
      end else begin
        kcnt = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s [%s] act=%0d exp=%0d t=%0t", tag, ph, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int e_adc, e_foc, e_exc, e_samp, e_idx, e_pos, c, r, len;
    e_adc = 0; e_foc = 0; e_exc = 0; e_samp = 0; e_idx = 0; e_pos = 0;
    if (rst_n && en_seen) begin
      len = mP * mN;
      c = kcur % mP;
      r = kcur % len;
      e_adc = (c == 0);
      e_foc = (c == mD);
      e_exc = (r == 0);
      e_pos = (r == len - 1);
      for (int j = 0; j < NS; j++)
        if (mofs[j] == r && mofs[j] < len && e_samp == 0) begin
          e_samp = 1; e_idx = j;
        end
    end
    if (!en_seen) begin
      chk("R1 quiet adc", adc, 0);
      chk("R1 quiet foc", foc, 0);
      chk("R1 quiet exc", exc, 0);
      chk("R1 quiet samp", samp, 0);
      chk("R1 quiet idx", sidx, 0);
      chk("R1 quiet pos", pos, 0);
    end else begin
      chk("R2 adc", adc, e_adc);
      chk("R3 foc", foc, e_foc);
      chk("R4 exc", exc, e_exc);
      chk("R6 R7 samp", samp, e_samp);
      chk("R6 idx", sidx, e_idx);
      chk("R5 pos", pos, e_pos);
    end
  end

  task automatic load_ofs();
    for (int j = 0; j < NS; j++) ofs_flat[j*RW +: RW] = RW'(ofs_tab[j]);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int tabA [NS] = '{0, 1, 4, 9, 13, 20, 21, 30, 33, 41, 47, 52, 58, 59, 70, 90};
    for (int j = 0; j < NS; j++) ofs_tab[j] = tabA[j];
    load_ofs();
    run(4);
    rst_n = 1'b1;
    run(3);
    // R1 R2 R3 R4 R5 R6 R7: P=20 D=7 N=3, last two entries past the period
    ph = "R6 R7 nonuniform";
    @(negedge clk); en = 1'b1;
    run(200);
    // R8: drop enable mid-period
    ph = "R8 restart";
    run(17);
    en = 1'b0;
    run(5);
    en = 1'b1;
    run(130);
    // R3: delay beyond period, single PWM cycle per resolver period
    ph = "R3 late delay";
    en = 1'b0;
    period = 16'd12; delay = 16'd25; ratio = 8'd1;
    for (int j = 0; j < NS; j++) ofs_tab[j] = j * 3;
    load_ofs();
    run(2);
    en = 1'b1;
    run(100);
    // default timing: 917 clocks, 6 cycles per resolver period
    ph = "R4 R5 defaults";
    en = 1'b0;
    period = 16'd917; delay = 16'd300; ratio = 8'd6;
    for (int j = 0; j < NS; j++) ofs_tab[j] = j * j * 20;
    load_ofs();
    run(2);
    en = 1'b1;
    run(11100);
    ph = "R1 reset again";
    rst_n = 1'b0;
    run(3);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule